// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core from four maskable sources: an external pin, the overflow of two timers and the completion of an analog-to-digital conversion. Each source latches a request flag that software can see and change through two 8-bit control registers. Each source also has its own enable bit, and one global enable gates all four.

At each instruction-cycle boundary, marked by the core with a one-cycle strobe, the controller checks three things: the global enable, that the core's return-address stack still has a free entry, and that some source has both its flag and its enable set. If all three hold, it picks the most urgent such source and issues a one-cycle call strobe together with that source's fixed vector address. In the same step it clears that source's flag and the global enable, so nested interrupts stay off until the core executes an interrupt-return. A plain subroutine return leaves the global enable alone.

The external pin passes through a synchronizer before its edges are detected. The edge that raises a request is selectable at run time.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both control registers read 0x00, `call_stb` is 0 and `vec_addr` is 0x00.
- R2: Register 0 holds the global enable at bit 0, the external, timer-0 and timer-1 enables at bits 1, 2 and 3, and the external, timer-0 and timer-1 flags at bits 4, 5 and 6; bit 7 reads 0. Register 1 holds the ADC enable at bit 0 and the ADC flag at bit 4; its other bits read 0. A write (`wr_en`=1, `wr_sel` 0 selects register 0 and 1 selects register 1) replaces every writable bit, and the new value shows on `ctl0_q`/`ctl1_q` after the next clock edge.
- R3: A one-cycle pulse on `tmr0_ovf`, `tmr1_ovf` or `adc_done`, or a detected pin edge, sets the matching flag whatever the enables are. A flag stays set until it is serviced or a register write clears it.
- R4: `edge_mode` 0 makes falling pin edges set the external flag, 1 makes rising edges set it, and 2 or 3 makes both do so. The pin passes through a two-stage synchronizer first, so the flag rises three clock edges after the pin changes.
- R5: An acknowledge happens at a clock edge only if all of these hold: `cycle_edge` is 1, the global enable is 1, `stack_full` is 0, `wr_en` is 0, and at least one flag has its enable set. The cycle after an acknowledge, `call_stb` is 1 for exactly one cycle. When no acknowledge happens, every flag stays as it was.
- R6: During `call_stb` the vector `vec_addr` is 0x04 for external, 0x08 for timer 0, 0x0C for timer 1 and 0x10 for ADC. At all other times `vec_addr` is 0x00.
- R7: When several enabled requests are pending at once, the external source wins over timer 0, timer 0 over timer 1, and timer 1 over ADC.
- R8: An acknowledge clears the flag of the serviced source and the global enable. Every other flag and every enable keeps its value.
- R9: A pulse on `ret_irq` sets the global enable. A pulse on `ret_plain` leaves it unchanged.
- R10: While `stack_full` is 1 no acknowledge happens, and pending flags stay latched.
- R11: A register write takes priority over a hardware flag set in the same cycle. A hardware set in the same cycle as the acknowledge of another source is kept.
- R12: A request that is pending and enabled is not serviced in cycles where `cycle_edge` is 0. It waits for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| edge_mode | input | 2 | Pin edge select: 0 falling, 1 rising, 2/3 both |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| adc_done | input | 1 | Conversion-complete pulse |
| cycle_edge | input | 1 | Instruction-cycle boundary strobe |
| stack_full | input | 1 | All return-address stack entries in use |
| ret_irq | input | 1 | Interrupt-return executed |
| ret_plain | input | 1 | Ordinary return executed |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 1 | Register select: 0 register 0, 1 register 1 |
| wr_data | input | 8 | Write data |
| call_stb | output | 1 | One-cycle interrupt call request |
| vec_addr | output | 8 | Vector address during the call |
| ctl0_q | output | 8 | Control register 0 contents |
| ctl1_q | output | 8 | Control register 1 contents |

## Verification
The bound checker watches every cycle for the following. Each call strobe must follow a boundary at which the global enable was set, the stack was not full and no write was in progress. The vector must be legal, and it must return to zero outside a call. The global enable must be clear during every call. No lower-priority vector may appear while the external request was both pending and enabled. Finally, an interrupt-return must always re-enable, and a plain return must never do so. Other behaviours only show up in the bench's directed scenarios: the three pin-edge modes with their synchronizer delay, the way the global enable and the serviced flag change across a full four-source priority sequence, flags that persist while gated, and the two same-cycle collisions of a write against a hardware set and an acknowledge against another source's set.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   localparam int NSRC = 4;

   // source index, lower index = higher priority
   localparam int SRC_EXT = 0;
   localparam int SRC_T0  = 1;
   localparam int SRC_T1  = 2;
   localparam int SRC_ADC = 3;

   // register 0 field positions
   localparam int B_GIE    = 0;
   localparam int B_EN_EXT = 1;
   localparam int B_EN_T0  = 2;
   localparam int B_EN_T1  = 3;
   localparam int B_FL_EXT = 4;
   localparam int B_FL_T0  = 5;
   localparam int B_FL_T1  = 6;
   // register 1 field positions
   localparam int B_EN_ADC = 0;
   localparam int B_FL_ADC = 4;

   typedef enum logic [1:0] {
      EDGE_FALL  = 2'd0,
      EDGE_RISE  = 2'd1,
      EDGE_BOTH  = 2'd2,
      EDGE_BOTH2 = 2'd3
   } edge_sel_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_RST     = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] edge_mode,
   output logic       hit
);
   import irq_vec_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("irq_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   lvl;
   logic                   rise;
   logic                   fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{PIN_RST}};
         last_q <= PIN_RST;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign lvl  = sync_q[SYNC_STAGES-1];
   assign rise = lvl & ~last_q;
   assign fall = ~lvl & last_q;

   always_comb begin
      unique case (edge_sel_e'(edge_mode))
         EDGE_FALL: hit = fall;
         EDGE_RISE: hit = rise;
         default:   hit = rise | fall;
      endcase
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int DATA_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic                           wr_sel,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [irq_vec_pkg::NSRC-1:0]   hw_set,
   input  logic [irq_vec_pkg::NSRC-1:0]   ack_clr,
   input  logic                           gie_clr,
   input  logic                           gie_set,
   output logic [irq_vec_pkg::NSRC-1:0]   flags,
   output logic [irq_vec_pkg::NSRC-1:0]   enables,
   output logic                           gie,
   output logic [DATA_W-1:0]              ctl0,
   output logic [DATA_W-1:0]              ctl1
);
   import irq_vec_pkg::*;

   if (DATA_W < 8) begin : g_bad_width
      $error("irq_flag_bank: DATA_W must be at least 8");
   end

   logic [NSRC-1:0] fl_q, fl_d;
   logic [NSRC-1:0] en_q, en_d;
   logic            gie_q, gie_d;
   logic            wr0, wr1;

   assign wr0 = wr_en & ~wr_sel;
   assign wr1 = wr_en & wr_sel;

   always_comb begin
      // hardware set survives a clear of the same cycle
      fl_d  = (fl_q & ~ack_clr) | hw_set;
      en_d  = en_q;
      gie_d = gie_q;
      if (gie_set) gie_d = 1'b1;
      if (gie_clr) gie_d = 1'b0;
      // software write wins over everything else
      if (wr0) begin
         gie_d           = wr_data[B_GIE];
         en_d[SRC_EXT]   = wr_data[B_EN_EXT];
         en_d[SRC_T0]    = wr_data[B_EN_T0];
         en_d[SRC_T1]    = wr_data[B_EN_T1];
         fl_d[SRC_EXT]   = wr_data[B_FL_EXT];
         fl_d[SRC_T0]    = wr_data[B_FL_T0];
         fl_d[SRC_T1]    = wr_data[B_FL_T1];
      end
      if (wr1) begin
         en_d[SRC_ADC]   = wr_data[B_EN_ADC];
         fl_d[SRC_ADC]   = wr_data[B_FL_ADC];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_q  <= '0;
         en_q  <= '0;
         gie_q <= 1'b0;
      end else begin
         fl_q  <= fl_d;
         en_q  <= en_d;
         gie_q <= gie_d;
      end
   end

   always_comb begin
      ctl0            = '0;
      ctl0[B_GIE]     = gie_q;
      ctl0[B_EN_EXT]  = en_q[SRC_EXT];
      ctl0[B_EN_T0]   = en_q[SRC_T0];
      ctl0[B_EN_T1]   = en_q[SRC_T1];
      ctl0[B_FL_EXT]  = fl_q[SRC_EXT];
      ctl0[B_FL_T0]   = fl_q[SRC_T0];
      ctl0[B_FL_T1]   = fl_q[SRC_T1];
      ctl1            = '0;
      ctl1[B_EN_ADC]  = en_q[SRC_ADC];
      ctl1[B_FL_ADC]  = fl_q[SRC_ADC];
   end

   assign flags   = fl_q;
   assign enables = en_q;
   assign gie     = gie_q;

   logic wr_unused;
   assign wr_unused = ^wr_data;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 4,
   parameter int VEC_STEP = 4
) (
   input  logic [irq_vec_pkg::NSRC-1:0] req,
   output logic [irq_vec_pkg::NSRC-1:0] grant,
   output logic                         any,
   output logic [VEC_W-1:0]             vec
);
   import irq_vec_pkg::*;

   localparam int VEC_LAST = VEC_BASE + (NSRC - 1) * VEC_STEP;

   if (VEC_LAST >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_arbiter: vector table does not fit VEC_W bits");
   end

   logic [VEC_W-1:0] vec_tab [NSRC];

   for (genvar i = 0; i < NSRC; i++) begin : g_tab
      assign vec_tab[i] = VEC_W'(VEC_BASE + i * VEC_STEP);
   end

   always_comb begin
      logic seen;
      seen  = 1'b0;
      grant = '0;
      vec   = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (req[i] && !seen) begin
            grant[i] = 1'b1;
            vec      = vec_tab[i];
         end
         seen = seen | req[i];
      end
      any = seen;
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int   DATA_W      = 8,
   parameter int   VEC_W       = 8,
   parameter int   VEC_BASE    = 4,
   parameter int   VEC_STEP    = 4,
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_RST     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_pin,
   input  logic [1:0]        edge_mode,
   input  logic              tmr0_ovf,
   input  logic              tmr1_ovf,
   input  logic              adc_done,
   input  logic              cycle_edge,
   input  logic              stack_full,
   input  logic              ret_irq,
   input  logic              ret_plain,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              call_stb,
   output logic [VEC_W-1:0]  vec_addr,
   output logic [DATA_W-1:0] ctl0_q,
   output logic [DATA_W-1:0] ctl1_q
);
   import irq_vec_pkg::*;

   logic            ext_hit;
   logic [NSRC-1:0] hw_set;
   logic [NSRC-1:0] flags, enables, grant, ack_clr;
   logic            gie, any, take;
   logic [VEC_W-1:0] vec_pick;
   logic            call_q;
   logic [VEC_W-1:0] vec_q;

   irq_edge_sync #(
      .SYNC_STAGES (SYNC_STAGES),
      .PIN_RST     (PIN_RST)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (ext_pin),
      .edge_mode (edge_mode),
      .hit       (ext_hit)
   );

   always_comb begin
      hw_set          = '0;
      hw_set[SRC_EXT] = ext_hit;
      hw_set[SRC_T0]  = tmr0_ovf;
      hw_set[SRC_T1]  = tmr1_ovf;
      hw_set[SRC_ADC] = adc_done;
   end

   irq_arbiter #(
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE),
      .VEC_STEP (VEC_STEP)
   ) u_arb (
      .req   (flags & enables),
      .grant (grant),
      .any   (any),
      .vec   (vec_pick)
   );

   // acknowledge only on a boundary, with room on the stack, no write racing
   assign take    = cycle_edge & gie & ~stack_full & ~wr_en & any;
   assign ack_clr = take ? grant : '0;

   irq_flag_bank #(
      .DATA_W (DATA_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .hw_set  (hw_set),
      .ack_clr (ack_clr),
      .gie_clr (take),
      .gie_set (ret_irq),
      .flags   (flags),
      .enables (enables),
      .gie     (gie),
      .ctl0    (ctl0_q),
      .ctl1    (ctl1_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         call_q <= 1'b0;
         vec_q  <= '0;
      end else begin
         call_q <= take;
         vec_q  <= take ? vec_pick : '0;
      end
   end

   assign call_stb = call_q;
   assign vec_addr = vec_q;

   // an ordinary return has no effect on this block
   logic ret_unused;
   assign ret_unused = ret_plain;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cycle_edge,
   input logic       stack_full,
   input logic       ret_irq,
   input logic       ret_plain,
   input logic       wr_en,
   input logic       call_stb,
   input logic [7:0] vec_addr,
   input logic [7:0] ctl0_q
);
   // R5: a call follows only a boundary with global enable and no write
   p_ack_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      call_stb |-> ($past(cycle_edge) && $past(ctl0_q[0]) && !$past(wr_en)));

   p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      call_stb |=> !call_stb);

   p_stack_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      call_stb |-> !$past(stack_full));

   p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      call_stb |-> (vec_addr == 8'h04 || vec_addr == 8'h08 ||
                    vec_addr == 8'h0C || vec_addr == 8'h10));

   p_vec_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !call_stb |-> (vec_addr == 8'h00));

   p_gie_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      call_stb |-> !ctl0_q[0]);

   p_ext_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (call_stb && vec_addr != 8'h04) |-> !$past(ctl0_q[4] && ctl0_q[1]));

   p_reti_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_irq && !wr_en && !ctl0_q[0]) |=> ctl0_q[0]);

   p_ret_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_plain && !ret_irq && !wr_en && !ctl0_q[0]) |=> !ctl0_q[0]);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cycle_edge (cycle_edge),
   .stack_full (stack_full),
   .ret_irq    (ret_irq),
   .ret_plain  (ret_plain),
   .wr_en      (wr_en),
   .call_stb   (call_stb),
   .vec_addr   (vec_addr),
   .ctl0_q     (ctl0_q)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_pin = 1'b0;
   logic [1:0] edge_mode = 2'd1;
   logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, adc_done = 1'b0;
   logic       cycle_edge = 1'b0, stack_full = 1'b0;
   logic       ret_irq = 1'b0, ret_plain = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       call_stb;
   logic [7:0] vec_addr, ctl0_q, ctl1_q;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #4 clk = ~clk;

   irq_vector_ctrl u_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_mode(edge_mode),
      .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .adc_done(adc_done),
      .cycle_edge(cycle_edge), .stack_full(stack_full),
      .ret_irq(ret_irq), .ret_plain(ret_plain),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .call_stb(call_stb), .vec_addr(vec_addr),
      .ctl0_q(ctl0_q), .ctl1_q(ctl1_q)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic boundary(output logic c, output logic [7:0] v);
      cycle_edge = 1'b1;
      @(negedge clk);
      cycle_edge = 1'b0;
      c = call_stb;
      v = vec_addr;
   endtask

   task automatic t_reset();
      chk("R1 ctl0 after reset", ctl0_q, 8'h00);
      chk("R1 ctl1 after reset", ctl1_q, 8'h00);
      chk("R1 call_stb after reset", call_stb, 1'b0);
      chk("R1 vec_addr after reset", vec_addr, 8'h00);
   endtask

   task automatic t_regs();
      logic seen;
      wr(1'b0, 8'hFF);
      chk("R2 ctl0 write all ones", ctl0_q, 8'h7F);
      wr(1'b1, 8'hFF);
      chk("R2 ctl1 write all ones", ctl1_q, 8'h11);
      seen = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         seen = seen | call_stb;
      end
      chk("R12 no call without boundary", seen, 1'b0);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h00);
      chk("R2 ctl0 cleared", ctl0_q, 8'h00);
      chk("R2 ctl1 cleared", ctl1_q, 8'h00);
   endtask

   task automatic t_flags();
      logic c; logic [7:0] v;
      tmr0_ovf = 1'b1; @(negedge clk); tmr0_ovf = 1'b0;
      chk("R3 timer0 flag set with enable off", ctl0_q, 8'h20);
      tmr1_ovf = 1'b1; @(negedge clk); tmr1_ovf = 1'b0;
      adc_done = 1'b1; @(negedge clk); adc_done = 1'b0;
      wait_n(5);
      chk("R3 flags persist ctl0", ctl0_q, 8'h60);
      chk("R3 adc flag persist ctl1", ctl1_q, 8'h10);
      boundary(c, v);
      chk("R5 no call with global enable off", c, 1'b0);
      chk("R5 flags kept when not acknowledged", ctl0_q, 8'h60);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h00);
      chk("R3 write clears flags", {ctl0_q, ctl1_q}, 16'h0000);
   endtask

   task automatic t_edges();
      edge_mode = 2'd1;
      ext_pin = 1'b1; wait_n(4);
      chk("R4 rising mode catches rise", ctl0_q[4], 1'b1);
      wr(1'b0, 8'h00);
      ext_pin = 1'b0; wait_n(4);
      chk("R4 rising mode ignores fall", ctl0_q[4], 1'b0);
      edge_mode = 2'd0;
      ext_pin = 1'b1; wait_n(4);
      chk("R4 falling mode ignores rise", ctl0_q[4], 1'b0);
      ext_pin = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R4 flag not yet up two edges after fall", ctl0_q[4], 1'b0);
      @(negedge clk);
      chk("R4 falling mode catches fall on third edge", ctl0_q[4], 1'b1);
      wr(1'b0, 8'h00);
      edge_mode = 2'd2;
      ext_pin = 1'b1; wait_n(4);
      chk("R4 both mode catches rise", ctl0_q[4], 1'b1);
      wr(1'b0, 8'h00);
      ext_pin = 1'b0; wait_n(4);
      chk("R4 both mode catches fall", ctl0_q[4], 1'b1);
      wr(1'b0, 8'h00);
      edge_mode = 2'd1;
   endtask

   task automatic t_priority();
      logic c; logic [7:0] v;
      wr(1'b0, 8'h7F);
      wr(1'b1, 8'h11);
      boundary(c, v);
      chk("R5 call on boundary", c, 1'b1);
      chk("R7 external first vector", v, 8'h04);
      chk("R8 ext flag and gie cleared", ctl0_q, 8'h6E);
      @(negedge clk);
      chk("R5 call lasts one cycle", call_stb, 1'b0);
      chk("R6 vector idle after call", vec_addr, 8'h00);
      ret_irq = 1'b1; @(negedge clk); ret_irq = 1'b0;
      chk("R9 interrupt-return sets gie", ctl0_q, 8'h6F);
      boundary(c, v);
      chk("R7 timer0 second vector", v, 8'h08);
      chk("R8 timer0 flag cleared", ctl0_q, 8'h4E);
      ret_irq = 1'b1; @(negedge clk); ret_irq = 1'b0;
      boundary(c, v);
      chk("R7 timer1 third vector", v, 8'h0C);
      chk("R8 timer1 flag cleared", ctl0_q, 8'h0E);
      ret_irq = 1'b1; @(negedge clk); ret_irq = 1'b0;
      boundary(c, v);
      chk("R6 adc vector", {7'd0, c, v}, {7'd0, 1'b1, 8'h10});
      chk("R8 adc flag cleared enable kept", ctl1_q, 8'h01);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h00);
   endtask

   task automatic t_gating();
      logic c; logic [7:0] v;
      wr(1'b0, 8'h25);
      stack_full = 1'b1;
      boundary(c, v);
      chk("R10 stack full blocks call", c, 1'b0);
      chk("R10 flag kept under stack full", ctl0_q, 8'h25);
      stack_full = 1'b0;
      wr(1'b0, 8'h21);
      boundary(c, v);
      chk("R5 source enable off blocks call", c, 1'b0);
      wr(1'b0, 8'h24);
      boundary(c, v);
      chk("R5 global enable off blocks call", c, 1'b0);
      wr(1'b0, 8'h25);
      boundary(c, v);
      chk("R5 call once unblocked", {c, v}, {1'b1, 8'h08});
   endtask

   task automatic t_ret();
      chk("R9 gie off before returns", ctl0_q[0], 1'b0);
      ret_plain = 1'b1; @(negedge clk); ret_plain = 1'b0;
      @(negedge clk);
      chk("R9 plain return leaves gie off", ctl0_q[0], 1'b0);
      ret_irq = 1'b1; @(negedge clk); ret_irq = 1'b0;
      chk("R9 interrupt-return sets gie", ctl0_q[0], 1'b1);
      wr(1'b0, 8'h00);
   endtask

   task automatic t_collide();
      logic c; logic [7:0] v;
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h00; tmr1_ovf = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tmr1_ovf = 1'b0;
      chk("R11 write beats hardware set", ctl0_q, 8'h00);
      wr(1'b0, 8'h13);
      tmr0_ovf = 1'b1;
      boundary(c, v);
      tmr0_ovf = 1'b0;
      chk("R11 ack during other set vector", {c, v}, {1'b1, 8'h04});
      chk("R11 timer0 set kept across ack", ctl0_q, 8'h22);
      wr(1'b0, 8'h00);
   endtask

   initial begin
      wait_n(4);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_flags();
      t_edges();
      t_priority();
      t_gating();
      t_ret();
      t_collide();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R1..: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule